// File: doc/BRIEF.md
# Dual-Path Camera Interrupt Controller

This block produces the interrupt requests of a camera capture unit that has two capture paths: an encoding path and a preview path. Each path signals completion with a one-cycle event pulse, and the block turns it into a request on that path's interrupt output. A separate overflow event raises a request on both outputs, but only when the overflow enable is set.

One global mode bit picks how the outputs behave. In edge mode, each event gives a one-cycle pulse and nothing is stored. In level mode, the request is held until software clears it. Software clears a path by writing 1 to that path's clear bit. Clear bits do not store the written value: each one acts only in the cycle of its write.

Configuration arrives as a write strobe with data bits: mode, overflow enable and one clear bit for each path. The register decoder that produces the strobe is outside the block.

Top module: `cam_irq_ctrl`

## Requirements
- R1: After reset both outputs are 0, the mode is edge (mode bit 0) and the overflow enable is 0.
- R2: In edge mode (mode bit 0), a request raised in cycle N drives that path's output high in cycle N+1 only. The output falls back to 0 when no request is raised, so no state is held.
- R3: In level mode (mode bit 1), a raised request sets that path's output in the next cycle. The output then stays high until it is cleared.
- R4: In level mode, a write with a path's clear bit at 1 and no new request for that path drives the output low in the next cycle.
- R5: A clear bit acts only in the cycle of its write and is not stored. After a clear, a later request holds the output high with no further write.
- R6: In edge mode the clear bits have no effect: an event in the same cycle as a clear write still produces its pulse.
- R7: In level mode, a request in the same cycle as that path's clear write wins, and the output stays high.
- R8: When the overflow enable is 1, an overflow event raises a request on both paths. When it is 0, overflow raises none.
- R9: A write that changes the mode bit forces both outputs to 0 in the next cycle, even if events arrive in that same cycle. The new mode governs from the cycle after the write.
- R10: The paths are independent: a clear or event on one path does not change the other path's output. Bit 0 of each vector is the encoding path and bit 1 is the preview path.
- R11: Mode and overflow enable take their new values from a write at the clock edge that samples it. They are reloaded by every write, clear-only writes included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_level_mode | input | 1 | Write data: 1 selects level mode, 0 selects edge mode |
| cfg_ovf_en | input | 1 | Write data: overflow interrupt enable |
| cfg_clr | input | NUM_PATHS | Write data: clear bit for each path, acting for one cycle only |
| path_evt | input | NUM_PATHS | Completion event pulse for each path |
| ovf_evt | input | 1 | Overflow event |
| irq | output | NUM_PATHS | Interrupt output for each path |

## Verification
The assertions assume that the strobe and data are valid together in a single cycle. They also assume that events and overflow are single-cycle samples, with no meaning attached to how long they stay high. The assertions also take for granted that a write changing the mode may coincide with events that are then lost. The bench drives every input at the falling edge. It keeps writes sparse in its random phase so that level-held requests actually persist between clears. It also places events, clears and mode changes in the same cycle on purpose to reach the priority cases.

// File: rtl/cam_irq_pkg.sv
package cam_irq_pkg;

  localparam int unsigned PATH_ENC = 0;
  localparam int unsigned PATH_PRV = 1;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } irq_mode_e;

  // next value of one path's interrupt flop
  function automatic logic irq_next(
    input logic      mode_chg,
    input irq_mode_e mode,
    input logic      raise,
    input logic      clr,
    input logic      cur
  );
    logic nxt;
    if (mode_chg)              nxt = 1'b0;
    else if (mode == MODE_EDGE) nxt = raise;
    else                       nxt = raise | (cur & ~clr);
    return nxt;
  endfunction

  // request source: own event or gated overflow
  function automatic logic raise_of(
    input logic evt,
    input logic ovf,
    input logic ovf_en
  );
    return evt | (ovf & ovf_en);
  endfunction

endpackage

// File: rtl/cam_irq_cfg.sv
module cam_irq_cfg
  import cam_irq_pkg::*;
#(
  parameter int unsigned NUM_PATHS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_level_mode,
  input  logic                 cfg_ovf_en,
  input  logic [NUM_PATHS-1:0] cfg_clr,
  output irq_mode_e            mode_q,
  output logic                 ovf_en_q,
  output logic                 mode_chg,
  output logic [NUM_PATHS-1:0] clr_pulse
);

  irq_mode_e mode_wr;

  assign mode_wr   = irq_mode_e'(cfg_level_mode);
  assign mode_chg  = cfg_wr && (mode_wr != mode_q);
  // clear bits are never stored: they live only for the write cycle
  assign clr_pulse = cfg_wr ? cfg_clr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_EDGE;
      ovf_en_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q   <= mode_wr;
      ovf_en_q <= cfg_ovf_en;
    end
  end

  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mode_q == irq_mode_e'($past(cfg_level_mode))) && (ovf_en_q == $past(cfg_ovf_en)));

  p_cfg_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(mode_q) && $stable(ovf_en_q));

  p_clr_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |-> (clr_pulse == '0));

endmodule

// File: rtl/cam_irq_src.sv
module cam_irq_src
  import cam_irq_pkg::*;
#(
  parameter int unsigned NUM_PATHS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PATHS-1:0] path_evt,
  input  logic                 ovf_evt,
  input  logic                 ovf_en_q,
  output logic [NUM_PATHS-1:0] raise
);

  genvar g;
  generate
    for (g = 0; g < NUM_PATHS; g++) begin : g_src
      assign raise[g] = raise_of(path_evt[g], ovf_evt, ovf_en_q);

      p_ovf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ovf_en_q && !path_evt[g]) |-> !raise[g]);
      p_ovf_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ovf_en_q) |-> raise[g]);
    end
  endgenerate

endmodule

// File: rtl/cam_irq_path.sv
module cam_irq_path
  import cam_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode_q,
  input  logic      mode_chg,
  input  logic      raise,
  input  logic      clr,
  output logic      irq_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next(mode_chg, mode_q, raise, clr, irq_q);
  end

  p_edge_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EDGE && !mode_chg && raise) |=> irq_q);
  p_edge_nohold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EDGE && !raise) |=> !irq_q);
  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEVEL && !mode_chg && irq_q && !clr) |=> irq_q);
  p_level_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEVEL && clr && !raise) |=> !irq_q);
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEVEL && !mode_chg && raise && clr) |=> irq_q);
  p_mode_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !irq_q);

endmodule

// File: rtl/cam_irq_ctrl.sv
module cam_irq_ctrl
  import cam_irq_pkg::*;
#(
  parameter int unsigned NUM_PATHS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_level_mode,
  input  logic                 cfg_ovf_en,
  input  logic [NUM_PATHS-1:0] cfg_clr,
  input  logic [NUM_PATHS-1:0] path_evt,
  input  logic                 ovf_evt,
  output logic [NUM_PATHS-1:0] irq
);

  irq_mode_e            mode_q;
  logic                 ovf_en_q;
  logic                 mode_chg;
  logic [NUM_PATHS-1:0] clr_pulse;
  logic [NUM_PATHS-1:0] raise;

  cam_irq_cfg #(.NUM_PATHS(NUM_PATHS)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_level_mode(cfg_level_mode),
    .cfg_ovf_en    (cfg_ovf_en),
    .cfg_clr       (cfg_clr),
    .mode_q        (mode_q),
    .ovf_en_q      (ovf_en_q),
    .mode_chg      (mode_chg),
    .clr_pulse     (clr_pulse)
  );

  cam_irq_src #(.NUM_PATHS(NUM_PATHS)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .path_evt(path_evt),
    .ovf_evt (ovf_evt),
    .ovf_en_q(ovf_en_q),
    .raise   (raise)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_PATHS; g++) begin : g_path
      cam_irq_path u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_q  (mode_q),
        .mode_chg(mode_chg),
        .raise   (raise[g]),
        .clr     (clr_pulse[g]),
        .irq_q   (irq[g])
      );
    end
  endgenerate

  p_ovf_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ovf_en_q && !mode_chg) |=> (irq == {NUM_PATHS{1'b1}}));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (irq == '0) && (mode_q == MODE_EDGE) && !ovf_en_q);

endmodule

// File: tb/test_cam_irq_ctrl.sv
module test_cam_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_level_mode = 1'b0, cfg_ovf_en = 1'b0;
  logic [NP-1:0] cfg_clr = '0, path_evt = '0;
  logic ovf_evt = 1'b0;
  logic [NP-1:0] irq;

  int total = 0, bad = 0;
  int m_level = 0, m_oven = 0;
  int m_irq [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_irq_ctrl #(.NUM_PATHS(NP)) i_cam_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_level_mode(cfg_level_mode),
    .cfg_ovf_en(cfg_ovf_en), .cfg_clr(cfg_clr), .path_evt(path_evt),
    .ovf_evt(ovf_evt), .irq(irq)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_oven = 0;
      foreach (m_irq[i]) m_irq[i] = 0;
    end else begin
      bit flush;
      flush = cfg_wr && (int'(cfg_level_mode) != m_level);
      foreach (m_irq[i]) begin
        bit req;
        req = path_evt[i] || (ovf_evt && m_oven != 0);
        if (flush) m_irq[i] = 0;
        else if (m_level == 0) m_irq[i] = req ? 1 : 0;
        else if (req) m_irq[i] = 1;
        else if (cfg_wr && cfg_clr[i]) m_irq[i] = 0;
      end
      if (cfg_wr) begin
        m_level = int'(cfg_level_mode);
        m_oven = int'(cfg_ovf_en);
      end
    end
  end

  task automatic compare(input string tag);
    for (int i = 0; i < NP; i++) begin
      total++;
      if (int'(irq[i]) != m_irq[i]) begin
        bad++;
        $display("FAIL %s path%0d: irq=%0d expected=%0d at %0t", tag, i, irq[i], m_irq[i], $time);
      end
    end
  endtask

  // drive one cycle at the falling edge, check at the next falling edge
  task automatic cyc(input string tag, input bit wr, input bit lvl, input bit oen,
                     input logic [NP-1:0] clr, input logic [NP-1:0] evt, input bit ovf);
    cfg_wr = wr; cfg_level_mode = lvl; cfg_ovf_en = oen; cfg_clr = clr;
    path_evt = evt; ovf_evt = ovf;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, '0, '0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        idle("R1", 2);
        // edge mode pulses
        cyc("R2", 0, 0, 0, '0, 2'b01, 0);
        idle("R2", 2);
        cyc("R2", 0, 0, 0, '0, 2'b11, 0);
        cyc("R2", 0, 0, 0, '0, 2'b10, 0);
        idle("R2", 1);
        // clear in edge mode ignored
        cyc("R6", 1, 0, 0, 2'b11, 2'b11, 0);
        idle("R6", 1);
        // overflow disabled then enabled (edge)
        cyc("R8", 0, 0, 0, '0, '0, 1);
        cyc("R11", 1, 0, 1, '0, '0, 0);
        cyc("R8", 0, 0, 0, '0, '0, 1);
        idle("R8", 1);
        // switch to level; event in that cycle is dropped
        cyc("R9", 1, 1, 1, '0, 2'b11, 0);
        cyc("R3", 0, 0, 0, '0, 2'b01, 0);
        idle("R3", 3);
        cyc("R10", 0, 0, 0, '0, 2'b10, 0);
        cyc("R10", 1, 1, 1, 2'b01, '0, 0);
        idle("R4", 2);
        cyc("R5", 0, 0, 0, '0, 2'b01, 0);
        idle("R5", 2);
        cyc("R7", 1, 1, 1, 2'b11, 2'b01, 0);
        cyc("R4", 1, 1, 1, 2'b11, '0, 0);
        cyc("R8", 0, 0, 0, '0, '0, 1);
        idle("R8", 2);
        cyc("R11", 1, 1, 0, '0, '0, 0);
        cyc("R8", 0, 0, 0, '0, '0, 1);
        idle("R8", 1);
        // held request flushed by mode change
        cyc("R3", 0, 0, 0, '0, 2'b11, 0);
        cyc("R9", 1, 0, 0, '0, 2'b11, 0);
        idle("R9", 2);
        cyc("R9", 1, 1, 0, '0, '0, 0);
        // random traffic with sparse writes
        for (int k = 0; k < 3000; k++) begin
          bit w;
          w = ($urandom_range(0, 9) == 0);
          cyc("R10", w, ($urandom_range(0, 5) != 0), $urandom_range(0, 1),
              2'($urandom_range(0, 3)), 2'(($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0),
              ($urandom_range(0, 15) == 0));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule